// File: doc/BRIEF.md
# Partition Bring-Up Sequencer

This block powers up one partition of a chip under hardware control. The caller provides a partition number and a one-cycle start pulse. The sequencer then works through a fixed series of steps. First it turns on the partition clock. Next it opens the partition's interconnect port. After that it releases the partition reset and removes output isolation. Finally it waits for the reset to be seen as gone. Three neighbours carry out these steps: a mode controller that applies clock and isolation settings on a commit strobe, an interconnect gate whose writes are guarded by an unlock bit, and a reset generator. Each neighbour reports its state back as one status bit per partition.

Each step is issued once. The sequencer then watches the status bit that belongs to that step before it moves on. A timeout limit, taken from an input at accept time, guards every wait. Requests that need no work end at once: partition 0, an out-of-range number, or a partition whose clock is already running. A busy flag covers the whole run, and the run ends with a one-cycle success or error pulse. All pins are plain control and status levels or strobes. There is no data stream, so no valid/ready back-pressure applies.

Top module: `part_bringup_seq`

## Requirements
- R1: A request for partition 0 ends with `done_o` two cycles after the start edge, and no commit, interconnect write or release is issued.
- R2: A partition number of NP (default 4) or above ends with `err_o` and `err_code_o` = 1 (invalid partition), and no action is issued.
- R3: If `mc_clk_stat_i` bit [part] is already 1 at the check, the run ends with `done_o` and no action is issued.
- R4: Step 1 issues one `mc_commit_o` with `mc_clk_en_o`=1 and `mc_iso_en_o`=1, then waits for `mc_clk_stat_i`[part]=1.
- R5: Step 2 issues three `ic_wr_o` writes in this order, written as (unlock, disable): (1,1), then (1,0), then a wait for `ic_dis_stat_i`[part]=0, then (0,0). The last write relocks the port.
- R6: Step 3 issues one `rg_release_o` pulse. Step 4 then issues one `mc_commit_o` with `mc_clk_en_o`=1 and `mc_iso_en_o`=0, and waits for `mc_iso_stat_i`[part]=0.
- R7: Step 5 waits for `rg_rst_stat_i`[part]=0 and then signals `done_o`. The full run shows the event order clock commit, three writes, release, isolation commit.
- R8: In any wait step, if the awaited status has not appeared when the cycle counter reaches `tmo_limit_i`, the run ends with `err_o` and `err_code_o` = 2 (timeout), and the block returns to idle. With limit L, a stall in step 1 gives the error L+4 cycles after the start edge.
- R9: `busy_o` is high from the cycle after the accepted start until the result cycle. A start while busy is ignored, and it neither changes the target nor adds a run.
- R10: At most one reset release is issued per run. `tgt_part_o` stays stable while busy. A release is only issued when the target's clock is on and its interconnect is enabled.
- R11: `done_o` (success) and `err_o` (error) are single-cycle pulses that never occur together. `err_code_o` is nonzero with `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in idle only |
| part_i | input | PW | Requested partition number |
| tmo_limit_i | input | TW | Wait timeout in cycles, latched at accept |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Error pulse |
| err_code_o | output | 2 | 1 invalid partition, 2 timeout |
| tgt_part_o | output | PW | Partition addressed by all strobes |
| mc_commit_o | output | 1 | Mode controller apply strobe |
| mc_clk_en_o | output | 1 | Requested clock enable with commit |
| mc_iso_en_o | output | 1 | Requested isolation enable with commit |
| mc_clk_stat_i | input | NP | Clock-active status per partition |
| mc_iso_stat_i | input | NP | Isolation-active status per partition |
| ic_wr_o | output | 1 | Interconnect control write strobe |
| ic_unlock_o | output | 1 | Unlock bit of the write |
| ic_disable_o | output | 1 | Disable bit of the write |
| ic_dis_stat_i | input | NP | Interconnect-disabled status per partition |
| rg_release_o | output | 1 | Reset release strobe |
| rg_rst_stat_i | input | NP | Reset-asserted status per partition |

## Verification
The bench runs the sequence against each early-exit pattern: partition 0, two out-of-range numbers, and a partition whose clock already runs. These show that each shortcut ends with the right result and issues no events. A full bring-up of a disabled partition checks the exact order and content of every event, together with the state the models are left in. A start pulse sent in the middle of this run shows that a busy sequencer ignores new requests. Two stalled runs, one with the clock never coming on and one with the reset never clearing, separate an early timeout from a late one. The first of them also checks the timeout latency to the cycle.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_CLK_CMT,
    S_CLK_WAIT,
    S_IC_OPEN,
    S_IC_EN,
    S_IC_WAIT,
    S_IC_CLOSE,
    S_RST_REL,
    S_ISO_CMT,
    S_ISO_WAIT,
    S_RST_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_BADPART = 2'd1,
    RES_TIMEOUT = 2'd2
  } res_code_e;

  function automatic logic is_wait(input seq_state_e s);
    return (s == S_CLK_WAIT) || (s == S_IC_WAIT) ||
           (s == S_ISO_WAIT) || (s == S_RST_WAIT);
  endfunction

endpackage

// File: rtl/pbs_stat_sel.sv
// Picks the status bits of the addressed partition out of the per-partition vectors.
module pbs_stat_sel #(
  parameter int NP = 4,
  parameter int PW = 3
) (
  input  logic [PW-1:0] part_i,
  input  logic [NP-1:0] clk_vec_i,
  input  logic [NP-1:0] iso_vec_i,
  input  logic [NP-1:0] dis_vec_i,
  input  logic [NP-1:0] rst_vec_i,
  output logic          part_ok_o,
  output logic          clk_on_o,
  output logic          iso_on_o,
  output logic          ic_dis_o,
  output logic          rst_on_o
);
  logic [NP-1:0] hit;

  for (genvar g = 0; g < NP; g++) begin : g_hit
    assign hit[g] = (part_i == PW'(g));
  end

  assign part_ok_o = |hit;
  assign clk_on_o  = |(clk_vec_i & hit);
  assign iso_on_o  = |(iso_vec_i & hit);
  assign ic_dis_o  = |(dis_vec_i & hit);
  assign rst_on_o  = |(rst_vec_i & hit);
endmodule

// File: rtl/pbs_wait_timer.sv
// Counts cycles spent in a wait step; flags expiry when the count reaches the limit.
module pbs_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (run_i && (cnt_q != limit_i)) begin
      cnt_q <= cnt_q + TW'(1);
    end
  end

  assign expired_o = run_i && (cnt_q == limit_i);
endmodule

// File: rtl/pbs_ctrl.sv
// Step sequencer: state register, request latch and result pulses.
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int PW = 3,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] part_i,
  input  logic [TW-1:0] tmo_limit_i,
  input  logic          part_ok_i,
  input  logic          clk_on_i,
  input  logic          iso_on_i,
  input  logic          ic_dis_i,
  input  logic          rst_on_i,
  input  logic          expired_i,
  output seq_state_e    state_o,
  output logic [PW-1:0] part_o,
  output logic [TW-1:0] tmo_o,
  output logic          timer_clr_o,
  output logic          wait_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    code_o
);
  seq_state_e    state_q, state_d;
  logic [PW-1:0] part_q;
  logic [TW-1:0] tmo_q;
  logic          fin_ok, fin_err;
  res_code_e     fin_code;
  logic          done_q, err_q;
  logic [1:0]    code_q;

  always_comb begin
    state_d  = state_q;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    fin_code = RES_OK;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_CHECK;
      S_CHECK: begin
        if (part_q == '0) begin
          fin_ok = 1'b1;
        end else if (!part_ok_i) begin
          fin_err  = 1'b1;
          fin_code = RES_BADPART;
        end else if (clk_on_i) begin
          fin_ok = 1'b1;
        end else begin
          state_d = S_CLK_CMT;
        end
      end
      S_CLK_CMT: state_d = S_CLK_WAIT;
      S_CLK_WAIT: begin
        if (clk_on_i) state_d = S_IC_OPEN;
        else if (expired_i) begin
          fin_err  = 1'b1;
          fin_code = RES_TIMEOUT;
        end
      end
      S_IC_OPEN: state_d = S_IC_EN;
      S_IC_EN:   state_d = S_IC_WAIT;
      S_IC_WAIT: begin
        if (!ic_dis_i) state_d = S_IC_CLOSE;
        else if (expired_i) begin
          fin_err  = 1'b1;
          fin_code = RES_TIMEOUT;
        end
      end
      S_IC_CLOSE: state_d = S_RST_REL;
      S_RST_REL:  state_d = S_ISO_CMT;
      S_ISO_CMT:  state_d = S_ISO_WAIT;
      S_ISO_WAIT: begin
        if (!iso_on_i) state_d = S_RST_WAIT;
        else if (expired_i) begin
          fin_err  = 1'b1;
          fin_code = RES_TIMEOUT;
        end
      end
      S_RST_WAIT: begin
        if (!rst_on_i) fin_ok = 1'b1;
        else if (expired_i) begin
          fin_err  = 1'b1;
          fin_code = RES_TIMEOUT;
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (fin_ok || fin_err) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      part_q  <= '0;
      tmo_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= 2'd0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok;
      err_q   <= fin_err;
      code_q  <= fin_err ? fin_code : RES_OK;
      if ((state_q == S_IDLE) && start_i) begin
        part_q <= part_i;
        tmo_q  <= tmo_limit_i;
      end
    end
  end

  assign state_o     = state_q;
  assign part_o      = part_q;
  assign tmo_o       = tmo_q;
  assign timer_clr_o = (state_d != state_q);
  assign wait_o      = is_wait(state_q);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign code_o      = code_q;
endmodule

// File: rtl/part_bringup_seq.sv
module part_bringup_seq
  import pbs_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 3,
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [PW-1:0] part_i,
  input  logic [TW-1:0] tmo_limit_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_code_o,
  output logic [PW-1:0] tgt_part_o,
  output logic          mc_commit_o,
  output logic          mc_clk_en_o,
  output logic          mc_iso_en_o,
  input  logic [NP-1:0] mc_clk_stat_i,
  input  logic [NP-1:0] mc_iso_stat_i,
  output logic          ic_wr_o,
  output logic          ic_unlock_o,
  output logic          ic_disable_o,
  input  logic [NP-1:0] ic_dis_stat_i,
  output logic          rg_release_o,
  input  logic [NP-1:0] rg_rst_stat_i
);
  seq_state_e    state;
  logic [PW-1:0] part_q;
  logic [TW-1:0] tmo_q;
  logic          part_ok, clk_on, iso_on, ic_dis, rst_on;
  logic          tmr_clr, tmr_run, tmr_exp;

  pbs_stat_sel #(.NP(NP), .PW(PW)) u_sel (
    .part_i    (part_q),
    .clk_vec_i (mc_clk_stat_i),
    .iso_vec_i (mc_iso_stat_i),
    .dis_vec_i (ic_dis_stat_i),
    .rst_vec_i (rg_rst_stat_i),
    .part_ok_o (part_ok),
    .clk_on_o  (clk_on),
    .iso_on_o  (iso_on),
    .ic_dis_o  (ic_dis),
    .rst_on_o  (rst_on)
  );

  pbs_wait_timer #(.TW(TW)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (tmr_clr),
    .run_i     (tmr_run),
    .limit_i   (tmo_q),
    .expired_o (tmr_exp)
  );

  pbs_ctrl #(.PW(PW), .TW(TW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .part_i      (part_i),
    .tmo_limit_i (tmo_limit_i),
    .part_ok_i   (part_ok),
    .clk_on_i    (clk_on),
    .iso_on_i    (iso_on),
    .ic_dis_i    (ic_dis),
    .rst_on_i    (rst_on),
    .expired_i   (tmr_exp),
    .state_o     (state),
    .part_o      (part_q),
    .tmo_o       (tmo_q),
    .timer_clr_o (tmr_clr),
    .wait_o      (tmr_run),
    .done_o      (done_o),
    .err_o       (err_o),
    .code_o      (err_code_o)
  );

  // Strobes and their data fields decode straight from the step state.
  assign busy_o       = (state != S_IDLE);
  assign tgt_part_o   = part_q;
  assign mc_commit_o  = (state == S_CLK_CMT) || (state == S_ISO_CMT);
  assign mc_clk_en_o  = mc_commit_o;
  assign mc_iso_en_o  = (state == S_CLK_CMT);
  assign ic_wr_o      = (state == S_IC_OPEN) || (state == S_IC_EN) || (state == S_IC_CLOSE);
  assign ic_unlock_o  = (state == S_IC_OPEN) || (state == S_IC_EN);
  assign ic_disable_o = (state == S_IC_OPEN);
  assign rg_release_o = (state == S_RST_REL);
endmodule

// File: rtl/part_bringup_seq_chk.sv
module part_bringup_seq_chk #(
  parameter int NP = 4,
  parameter int PW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [1:0]    err_code_o,
  input logic [PW-1:0] tgt_part_o,
  input logic          mc_commit_o,
  input logic          mc_clk_en_o,
  input logic          ic_wr_o,
  input logic          rg_release_o,
  input logic [NP-1:0] mc_clk_stat_i,
  input logic [NP-1:0] ic_dis_stat_i
);
  localparam int IW = (NP > 1) ? $clog2(NP) : 1;

  logic rel_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_seen_q <= 1'b0;
    else if (!busy_o) rel_seen_q <= 1'b0;
    else if (rg_release_o) rel_seen_q <= 1'b1;
  end

  a_r11_result_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  a_r11_err_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 2'd0));
  a_r9_idle_at_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  a_r9_actions_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mc_commit_o || ic_wr_o || rg_release_o) |-> busy_o);
  a_r10_target_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tgt_part_o));
  a_r10_single_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_release_o |-> !rel_seen_q);
  a_r10_release_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_release_o |-> (mc_clk_stat_i[tgt_part_o[IW-1:0]] && !ic_dis_stat_i[tgt_part_o[IW-1:0]]));
  a_r4_commit_clock_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_commit_o |-> mc_clk_en_o);
  a_r7_no_overlap_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mc_commit_o, ic_wr_o, rg_release_o}));
endmodule

bind part_bringup_seq part_bringup_seq_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .err_code_o    (err_code_o),
  .tgt_part_o    (tgt_part_o),
  .mc_commit_o   (mc_commit_o),
  .mc_clk_en_o   (mc_clk_en_o),
  .ic_wr_o       (ic_wr_o),
  .rg_release_o  (rg_release_o),
  .mc_clk_stat_i (mc_clk_stat_i),
  .ic_dis_stat_i (ic_dis_stat_i)
);

// File: tb/part_bringup_seq_tb_top.sv
module part_bringup_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int PW = 3;
  localparam int TW = 8;
  localparam logic [7:0] TMO = 8'd20;
  // event codes: 1 clock commit, 2 isolation commit, 3 write(1,1), 4 write(1,0), 5 write(0,0), 6 release
  localparam logic [23:0] ORD_FULL = {6'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd6, 3'd2};
  localparam logic [23:0] ORD_CLK  = 24'd1;

  typedef struct packed {
    logic [1:0]    code;
    logic [PW-1:0] part;
    logic [23:0]   ord;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] part = '0;
  logic busy, done, err;
  logic [1:0] code;
  logic [PW-1:0] tgt;
  logic commit, clk_en, iso_en, ic_wr, ic_unl, ic_dis, rel;
  logic [NP-1:0] clk_st, iso_st, dis_st, rst_st, unl_reg, dis_reg, dis_d1;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic mc_stuck = 1'b0;
  logic rg_stuck = 1'b0;
  exp_t sb_q[$];
  logic [23:0] ord_acc = '0;
  logic part_bad = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  part_bringup_seq #(.NP(NP), .PW(PW), .TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .part_i(part), .tmo_limit_i(TMO),
    .busy_o(busy), .done_o(done), .err_o(err), .err_code_o(code), .tgt_part_o(tgt),
    .mc_commit_o(commit), .mc_clk_en_o(clk_en), .mc_iso_en_o(iso_en),
    .mc_clk_stat_i(clk_st), .mc_iso_stat_i(iso_st),
    .ic_wr_o(ic_wr), .ic_unlock_o(ic_unl), .ic_disable_o(ic_dis), .ic_dis_stat_i(dis_st),
    .rg_release_o(rel), .rg_rst_stat_i(rst_st)
  );

  // Responder models: mode controller (3-cycle), interconnect gate (2-cycle status), reset generator (4-cycle).
  logic [2:0] mc_cnt, rg_cnt;
  logic [1:0] mc_p, rg_p;
  logic mc_pce, mc_osse;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_st <= 4'b0101; iso_st <= 4'b1010; dis_st <= 4'b1010; dis_reg <= 4'b1010;
      dis_d1 <= 4'b1010; unl_reg <= '0; rst_st <= 4'b1010;
      mc_cnt <= '0; rg_cnt <= '0; mc_p <= '0; rg_p <= '0; mc_pce <= 1'b0; mc_osse <= 1'b0;
    end else begin
      if (commit && !mc_stuck) begin
        mc_cnt <= 3'd3; mc_p <= tgt[1:0]; mc_pce <= clk_en; mc_osse <= iso_en;
      end else if (mc_cnt != 0) begin
        mc_cnt <= mc_cnt - 3'd1;
        if (mc_cnt == 3'd1) begin
          clk_st[mc_p] <= mc_pce;
          iso_st[mc_p] <= mc_osse;
        end
      end
      if (ic_wr) begin
        if (unl_reg[tgt[1:0]]) dis_reg[tgt[1:0]] <= ic_dis;
        unl_reg[tgt[1:0]] <= ic_unl;
      end
      dis_d1 <= dis_reg;
      dis_st <= dis_d1;
      if (rel && !rg_stuck) begin
        rg_cnt <= 3'd4; rg_p <= tgt[1:0];
      end else if (rg_cnt != 0) begin
        rg_cnt <= rg_cnt - 3'd1;
        if (rg_cnt == 3'd1) rst_st[rg_p] <= 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Monitor: records events, pops expected results from the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (commit || ic_wr || rel) begin
        if (tgt != (sb_q.size() != 0 ? sb_q[0].part : '0)) part_bad = 1'b1;
        if (commit) ord_acc = (ord_acc << 3) | (iso_en ? 24'd1 : 24'd2);
        if (ic_wr) ord_acc = (ord_acc << 3) | (ic_unl ? (ic_dis ? 24'd3 : 24'd4) : 24'd5);
        if (rel) ord_acc = (ord_acc << 3) | 24'd6;
      end
      if (done || err) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R9 extra result", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check((err ? code : 2'd0) == e.code, "R11 result code", int'(err ? code : 2'd0), int'(e.code));
          check(done == (e.code == 2'd0), "R11 done/err pulse", int'(done), int'(e.code == 2'd0));
          check(ord_acc == e.ord, "R7 event order", int'(ord_acc), int'(e.ord));
          check(!part_bad, "R10 event target", int'(part_bad), 0);
        end
        ord_acc = '0;
        part_bad = 1'b0;
      end
    end
  end

  task automatic run(input logic [PW-1:0] p, input logic [1:0] ecode, input logic [23:0] eord,
                     input bit ign, input int elat, input string req);
    int lat;
    exp_t e;
    e.code = ecode; e.part = p; e.ord = eord;
    sb_q.push_back(e);
    @(negedge clk);
    start = 1'b1; part = p;
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      start = 1'b0;
      if (lat == 1) check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
      if (ign && lat == 2) begin start = 1'b1; part = 3'd3; end
      if (ign && lat == 3) start = 1'b0;
      if (done || err) break;
      if (lat > 1 && !busy) begin check(1'b0, "R9 busy held", 0, 1); break; end
      if (lat > 2000) begin check(1'b0, "R8 run hung", lat, 0); break; end
    end
    if (elat != 0) check(lat == elat, req, lat, elat);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !err, "reset idle", int'({busy, done, err}), 0);
    check(!commit && !ic_wr && !rel, "reset strobes", int'({commit, ic_wr, rel}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(3'd0, 2'd0, 24'd0, 1'b0, 2, "R1 partition 0 latency");
    run(3'd4, 2'd1, 24'd0, 1'b0, 2, "R2 partition 4 rejected");
    run(3'd7, 2'd1, 24'd0, 1'b0, 0, "R2 partition 7 rejected");
    run(3'd2, 2'd0, 24'd0, 1'b0, 2, "R3 already enabled");
    run(3'd1, 2'd0, ORD_FULL, 1'b1, 0, "R7 full bring-up");
    check(clk_st[1] == 1'b1, "R4 clock on", int'(clk_st[1]), 1);
    check(dis_st[1] == 1'b0 && unl_reg[1] == 1'b0, "R5 port enabled and relocked",
          int'({dis_st[1], unl_reg[1]}), 0);
    check(iso_st[1] == 1'b0, "R6 isolation removed", int'(iso_st[1]), 0);
    check(rst_st[1] == 1'b0, "R7 reset released", int'(rst_st[1]), 0);
    check(clk_st[3] == 1'b0 && sb_q.size() == 0, "R9 ignored start left partition 3",
          int'(clk_st[3]), 0);
    mc_stuck = 1'b1;
    run(3'd3, 2'd2, ORD_CLK, 1'b0, int'(TMO) + 4, "R8 timeout latency in clock wait");
    mc_stuck = 1'b0;
    rg_stuck = 1'b1;
    run(3'd3, 2'd2, ORD_FULL, 1'b0, 0, "R8 timeout in reset wait");
    check(rst_st[3] == 1'b1, "R10 reset still held", int'(rst_st[3]), 1);
    rg_stuck = 1'b0;
    run(3'd3, 2'd0, 24'd0, 1'b0, 2, "R3 skip after partial run");
    check(sb_q.size() == 0, "R11 all results seen", sb_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end
endmodule